// File: doc/BRIEF.md
# Reduced-Precision Redundancy Output Corrector

This block sits at the output of a filter that runs at a supply voltage below the level its timing needs. Such a filter can produce samples whose upper bits are wrong. Next to it runs a narrow copy of the same filter. The copy works on inputs cut down to fewer bits, so its result is coarse. Its logic is also short enough that it never misses timing. For each sample the corrector compares the wide result with the coarse one. The true value always lies within a known rounding-noise distance of the coarse value.

If the two results differ by no more than a programmed bound, the wide result is taken as correct and passed on. If they differ by more, the wide result must have been hit by a timing error. The corrector then outputs the coarse value instead, with its missing low bits filled with zeros, and raises a flag for that sample. The bound is set larger for narrower copies, because their rounding noise grows as the copy gets narrower.

The difference is computed one bit wider than the operands, so even the most extreme pair of inputs cannot overflow. The stage has one register, and the valid strobe travels through it alongside the data.

Top module: `rpr_corrector`

## Requirements
- R1: While reset is asserted and after its release, before any valid input, `out_valid`, `out_fixed` and `out_data` are all zero.
- R2: `out_valid` equals `in_valid` from the previous clock cycle, so every accepted sample appears exactly one cycle after it is presented.
- R3: When |main − aligned replica| ≤ `bound_in`, `out_data` equals `main_in` and `out_fixed` is 0. Both operands are two's complement. The aligned replica is `rep_in` placed in the top RPR_W bits, with MAIN_W−RPR_W zero bits below it.
- R4: When |main − aligned replica| > `bound_in`, `out_data` equals the aligned replica (low MAIN_W−RPR_W bits zero) and `out_fixed` is 1 for that sample only.
- R5: A difference exactly equal to the bound counts as within the bound. A difference one larger is corrected.
- R6: The difference is evaluated without overflow across the full operand range. For example, main 0x7FFF against replica 0x200 (aligned 0x8000) gives a magnitude of 65535.
- R7: In a cycle with `in_valid` low, the next cycle shows `out_valid` 0 and `out_fixed` 0, and `out_data` keeps its previous value.
- R8: With a bound of zero, only an exact match between main and aligned replica passes the main value; any other value is replaced.
- R9: A main sample whose bit MAIN_W−1, MAIN_W−2 or MAIN_W−3 was flipped by a timing error is replaced by the aligned replica, as long as the bound is below 2^(MAIN_W−3) minus the rounding error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe for the inputs below |
| main_in | input | MAIN_W | Full-precision filter result, two's complement, possibly corrupted |
| rep_in | input | RPR_W | Reduced-precision replica result, two's complement, upper bits of the same scale |
| bound_in | input | MAIN_W | Unsigned rounding-noise bound |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_data | output | MAIN_W | Selected sample |
| out_fixed | output | 1 | High when the replica replaced the main value |

## Verification
A wrong select or compare decision shows at the ports on the very next cycle after the affected sample. It appears either as the full-precision value left through when a replaced value was due, or as a value with zeroed low bits and a raised flag where the main value was due. A fault in the alignment or the wide subtraction shows only for operands near the range ends or near the bound. This is why the equality edge, the zero bound and the most extreme sign pairs are each driven directly. Lost valid timing shows as a sample appearing one cycle late or early, or as held data changing during idle cycles.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    typedef enum logic {
        SEL_MAIN    = 1'b0,
        SEL_REPLICA = 1'b1
    } sel_e;
endpackage

// File: rtl/rpr_align.sv
module rpr_align #(
    parameter int MAIN_W = 16,
    parameter int RPR_W  = 10
) (
    input  logic [RPR_W-1:0]  rep_in,
    output logic [MAIN_W-1:0] rep_ext
);
    localparam int PAD_W = MAIN_W - RPR_W;

    generate
        if (PAD_W == 0) begin : g_same
            assign rep_ext = rep_in;
        end else begin : g_pad
            assign rep_ext = {rep_in, {PAD_W{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/rpr_absdiff.sv
module rpr_absdiff #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W:0]   mag
);
    logic signed [W:0] diff;

    always_comb begin
        diff = $signed({a_in[W-1], a_in}) - $signed({b_in[W-1], b_in});
        if (diff[W]) begin
            mag = -diff;
        end else begin
            mag = diff;
        end
    end
endmodule

// File: rtl/rpr_select.sv
module rpr_select
    import rpr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W:0]   mag,
    input  logic [W-1:0] bound,
    input  logic [W-1:0] main_val,
    input  logic [W-1:0] rep_val,
    output sel_e         sel,
    output logic [W-1:0] pick
);
    always_comb begin
        if (mag > {1'b0, bound}) begin
            sel = SEL_REPLICA;
        end else begin
            sel = SEL_MAIN;
        end
        pick = (sel == SEL_REPLICA) ? rep_val : main_val;
    end
endmodule

// File: rtl/rpr_corrector.sv
module rpr_corrector
    import rpr_pkg::*;
#(
    parameter int MAIN_W = 16,
    parameter int RPR_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MAIN_W-1:0] main_in,
    input  logic [RPR_W-1:0]  rep_in,
    input  logic [MAIN_W-1:0] bound_in,
    output logic              out_valid,
    output logic [MAIN_W-1:0] out_data,
    output logic              out_fixed
);
    localparam int MAG_W = MAIN_W + 1;

    typedef struct packed {
        logic              valid;
        logic              fixed;
        logic [MAIN_W-1:0] data;
    } stage_t;

    stage_t            st_d, st_q;
    logic [MAIN_W-1:0] rep_ext;
    logic [MAG_W-1:0]  mag;
    sel_e              sel;
    logic [MAIN_W-1:0] pick;

    rpr_align #(.MAIN_W(MAIN_W), .RPR_W(RPR_W)) u_align (
        .rep_in  (rep_in),
        .rep_ext (rep_ext)
    );

    rpr_absdiff #(.W(MAIN_W)) u_diff (
        .a_in (main_in),
        .b_in (rep_ext),
        .mag  (mag)
    );

    rpr_select #(.W(MAIN_W)) u_sel (
        .mag      (mag),
        .bound    (bound_in),
        .main_val (main_in),
        .rep_val  (rep_ext),
        .sel      (sel),
        .pick     (pick)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.fixed = 1'b0;
        if (in_valid) begin
            st_d.data  = pick;
            st_d.fixed = (sel == SEL_REPLICA);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_fixed = st_q.fixed;
    assign out_data  = st_q.data;
endmodule

// File: rtl/rpr_corrector_chk.sv
module rpr_corrector_chk #(
    parameter int MAIN_W = 16,
    parameter int RPR_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [MAIN_W-1:0] main_in,
    input logic [RPR_W-1:0]  rep_in,
    input logic              out_valid,
    input logic [MAIN_W-1:0] out_data,
    input logic              out_fixed
);
    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R4
    fixed_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_fixed |-> out_valid);
    // R4
    fixed_replica_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_fixed || out_data[MAIN_W-1 -: RPR_W] == $past(rep_in)));
    // R3
    pass_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_fixed || out_data == $past(main_in)));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && !out_fixed));
endmodule

bind rpr_corrector rpr_corrector_chk #(.MAIN_W(MAIN_W), .RPR_W(RPR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .main_in   (main_in),
    .rep_in    (rep_in),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_fixed (out_fixed)
);

// File: tb/sim_rpr_corrector.sv
module sim_rpr_corrector;
    localparam int MW = 16;
    localparam int RW = 10;
    localparam int SH = MW - RW;

    typedef struct {
        logic [MW-1:0] data;
        logic          fixed;
        string         rq;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [MW-1:0] main_in = '0;
    logic [RW-1:0] rep_in = '0;
    logic [MW-1:0] bound_in = '0;
    logic          out_valid;
    logic [MW-1:0] out_data;
    logic          out_fixed;

    exp_t          sb[$];
    int            n_chk = 0;
    int            n_bad = 0;
    logic          mon_on = 1'b0;
    logic [MW-1:0] last_out = '0;

    always #4 clk = ~clk;

    rpr_corrector #(.MAIN_W(MW), .RPR_W(RW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .main_in   (main_in),
        .rep_in    (rep_in),
        .bound_in  (bound_in),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_fixed (out_fixed)
    );

    task automatic check(input bit ok, input string rq, input logic [MW-1:0] act,
                         input logic [MW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic send(input logic [MW-1:0] m, input logic [RW-1:0] r,
                        input logic [MW-1:0] b, input string rq);
        int   mi;
        int   ri;
        int   d;
        exp_t e;
        mi = int'($signed(m));
        ri = int'($signed(r)) * (1 << SH);
        d  = mi - ri;
        if (d < 0) d = -d;
        e.rq = rq;
        if (d > int'(b)) begin
            e.data  = MW'(ri);
            e.fixed = 1'b1;
        end else begin
            e.data  = m;
            e.fixed = 1'b0;
        end
        in_valid = 1'b1;
        main_in  = m;
        rep_in   = r;
        bound_in = b;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            main_in  = MW'($urandom);
            rep_in   = RW'($urandom);
            @(negedge clk);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", out_data, '0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_data == e.data, e.rq, out_data, e.data);
                    check(out_fixed == e.fixed, e.rq, MW'(out_fixed), MW'(e.fixed));
                    last_out = e.data;
                end
            end else begin
                // R7: idle cycle holds data, no flag
                check(out_data == last_out && !out_fixed, "R7", out_data, last_out);
            end
        end
    end

    initial begin
        #(8 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [MW-1:0] x;
        logic [MW-1:0] m;
        logic [RW-1:0] r;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!out_valid && !out_fixed && out_data == '0, "R1", out_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_fixed && out_data == '0, "R1", out_data, '0);
        mon_on = 1'b1;

        // R3 / R2: within bound, back-to-back
        send(16'd1000, 10'd15, 16'd100, "R3");
        send(16'hFF00, 10'h3FC, 16'd63, "R3");
        // R4: out of bound
        send(16'd5000, 10'd15, 16'd100, "R4");
        idle(2);
        // R5: equality edge (diff 40)
        send(16'd1000, 10'd15, 16'd40, "R5");
        send(16'd1000, 10'd15, 16'd39, "R5");
        // R6: extreme operands
        send(16'h7FFF, 10'h200, 16'hFFFF, "R6");
        send(16'h7FFF, 10'h200, 16'hFFFE, "R6");
        send(16'h8000, 10'h1FF, 16'hFFFF, "R6");
        send(16'h8000, 10'h1FF, 16'd100, "R6");
        idle(1);
        // R8: zero bound
        send(16'd960, 10'd15, 16'd0, "R8");
        send(16'd961, 10'd15, 16'd0, "R8");
        send(16'd959, 10'd15, 16'd0, "R8");
        idle(3);

        // R9: random upper-bit fault injection, bound 63
        for (int i = 0; i < 400; i++) begin
            x = MW'($urandom);
            r = x[MW-1:SH];
            m = x;
            if (($urandom % 3) == 0) m[MW - 1 - ($urandom % 3)] ^= 1'b1;
            send(m, r, 16'd63, (m != x) ? "R9" : "R3");
            if (($urandom % 5) == 0) idle(1);
        end
        idle(3);
        // R2: every sample came out
        check(sb.size() == 0, "R2", MW'(sb.size()), '0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule